// File: doc/BRIEF.md
# Line Code Violation and Zero-Run Detector

This block watches a received line in dual-rail form: one rail for positive marks, one for negative marks, and a strobe that marks each bit period. It raises a single error output for one bit period whenever it finds a bipolar violation. A bipolar violation is a mark with the same polarity as the mark before it, or a mark present on both rails at once. When the zero-substitution decoder is enabled, the violations that belong to a legal substitution code word are not reported. B8ZS is used on T1 lines and HDB3 on E1 lines. The same output can also report runs of zeros that are too long for the selected code.

Every received bit passes through an eight-bit delay line before its event reaches the output. The delay lets the block see a complete substitution word before it decides whether a violation inside that word is genuine. The output is therefore eight bit periods behind the line, and it changes only on strobe cycles.

Top module: `bpv_exz_detector`

## Requirements
- R1: `bpv_pulse` changes only on a clock edge where `bit_en` is high. The event for bit n appears after strobe n+8 and holds for exactly that one bit period.
- R2: A mark on exactly one rail (`rail_p` = positive, `rail_n` = negative) is a violation when its polarity equals that of the previous single-rail mark. The first mark after reset is never a violation.
- R3: A mark on both rails in the same bit is always a violation. It is never masked and does not change the polarity reference.
- R4: With `dec_en`=1 and `code_sel`=1 (B8ZS), an eight-bit window of the form 0,0,0,V,B,0,V,B (oldest first) clears both of its V violations. V is a single-rail violation and B is a non-violating mark.
- R5: With `dec_en`=1 and `code_sel`=2 (HDB3), a window of the form 0,0,0,V or B,0,0,V clears the violation on its V.
- R6: With `dec_en`=0, no violation is masked, whatever the code.
- R7: With `exz_en`=1, `e1_mode`=0 and `code_sel` 0 (AMI, value 3 also treated as AMI), the 16th consecutive zero is an event. The event fires once per run, and only a mark ends the run.
- R8: With `exz_en`=1, `e1_mode`=0 and `code_sel`=1, the 8th consecutive zero is an event, once per run.
- R9: No zero-run event is produced when `exz_en`=0, when `e1_mode`=1, or when `code_sel`=2.
- R10: During and after reset the output is low. The delay line and the zero run start empty, so bits before the first strobe count as zeros but are not counted in the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe, one cycle per received bit |
| rail_p | input | 1 | Positive mark rail |
| rail_n | input | 1 | Negative mark rail |
| dec_en | input | 1 | Substitution decoder enable (masks legal violations) |
| code_sel | input | 2 | 0 AMI, 1 B8ZS, 2 HDB3, 3 treated as AMI |
| e1_mode | input | 1 | E1 operation; disables zero-run events |
| exz_en | input | 1 | Zero-run event enable |
| bpv_pulse | output | 1 | Error pulse, one bit period per event |

## Verification
The bench uses random AMI streams with only alternating marks and zeros, so any pulse there exposes a false violation. Streams with injected same-polarity marks and dual-rail marks separate the two violation causes. Legal B8ZS and HDB3 code words are inserted with the decoder both on and off, which shows whether only those words are masked. Long zero runs of 6 to 40 bits under each code, E1 and enable setting find the exact threshold, confirm there is one event per run, and confirm the disabled cases stay quiet. Random idle gaps between strobes show that the pulse lasts the whole bit period.

// File: rtl/bpv_pkg.sv
package bpv_pkg;
  localparam int WIN = 8;

  typedef enum logic [1:0] {
    CODE_AMI  = 2'd0,
    CODE_B8ZS = 2'd1,
    CODE_HDB3 = 2'd2,
    CODE_RSVD = 2'd3
  } line_code_e;

  // zero-run threshold in bits, 0 means disabled
  function automatic int unsigned exz_limit(input logic [1:0] code, input logic e1,
                                            input logic en, input int unsigned ami_run,
                                            input int unsigned b8_run);
    if (!en || e1) return 0;
    case (code)
      CODE_B8ZS: return b8_run;
      CODE_HDB3: return 0;
      default:   return ami_run;
    endcase
  endfunction

  // bit 0 is the newest bit of the window
  function automatic logic [WIN-1:0] b8zs_clear(input logic [WIN-1:0] mk,
                                                input logic [WIN-1:0] vi,
                                                input logic [WIN-1:0] du);
    logic [WIN-1:0] sv, bm;
    sv = mk & vi & ~du;
    bm = mk & ~vi;
    if (!mk[7] && !mk[6] && !mk[5] && sv[4] && bm[3] && !mk[2] && sv[1] && bm[0])
      return 8'b0001_0010;
    return '0;
  endfunction

  function automatic logic [WIN-1:0] hdb3_clear(input logic [WIN-1:0] mk,
                                                input logic [WIN-1:0] vi,
                                                input logic [WIN-1:0] du);
    logic lead_ok;
    lead_ok = !mk[3] || (mk[3] && !vi[3]);
    if (lead_ok && !mk[2] && !mk[1] && mk[0] && vi[0] && !du[0])
      return 8'b0000_0001;
    return '0;
  endfunction
endpackage

// File: rtl/bpv_mark_tracker.sv
module bpv_mark_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rail_p,
  input  logic rail_n,
  output logic is_mark,
  output logic is_dual,
  output logic raw_vio
);
  logic seen_q, pol_q;   // pol: 1 = negative
  logic single;

  assign single  = rail_p ^ rail_n;
  assign is_dual = rail_p & rail_n;
  assign is_mark = rail_p | rail_n;
  assign raw_vio = is_dual | (single & seen_q & (rail_n == pol_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (bit_en && single) begin
      seen_q <= 1'b1;
      pol_q  <= rail_n;
    end
  end
endmodule

// File: rtl/bpv_zero_run.sv
module bpv_zero_run #(
  parameter int unsigned AMI_RUN  = 16,
  parameter int unsigned B8ZS_RUN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       is_mark,
  input  logic [1:0] code_sel,
  input  logic       e1_mode,
  input  logic       exz_en,
  output logic       exz_hit
);
  import bpv_pkg::*;
  localparam int unsigned MAXR = (AMI_RUN > B8ZS_RUN) ? AMI_RUN : B8ZS_RUN;
  localparam int CW = $clog2(MAXR + 1);

  logic [CW-1:0] cnt_q;
  int unsigned   lim;

  assign lim     = exz_limit(code_sel, e1_mode, exz_en, AMI_RUN, B8ZS_RUN);
  assign exz_hit = bit_en && !is_mark && (lim != 0) && (32'(cnt_q) + 32'd1 == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (bit_en) begin
      if (is_mark)             cnt_q <= '0;
      else if (cnt_q != CW'(MAXR)) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bpv_subst_window.sv
module bpv_subst_window (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       is_mark,
  input  logic       is_dual,
  input  logic       raw_vio,
  input  logic       exz_hit,
  input  logic       dec_en,
  input  logic [1:0] code_sel,
  output logic       mask_hit,
  output logic       err_q
);
  import bpv_pkg::*;

  logic [WIN-2:0] mk_q, du_q;
  logic [WIN-1:0] vi_q, ez_q;
  logic [WIN-1:0] win_mk, win_du, win_vi, win_ez, clr;

  assign win_mk = {mk_q, is_mark};
  assign win_du = {du_q, is_dual};
  assign win_vi = {vi_q[WIN-2:0], raw_vio};
  assign win_ez = {ez_q[WIN-2:0], exz_hit};

  always_comb begin
    clr = '0;
    if (dec_en) begin
      case (code_sel)
        CODE_B8ZS: clr = b8zs_clear(win_mk, win_vi, win_du);
        CODE_HDB3: clr = hdb3_clear(win_mk, win_vi, win_du);
        default:   clr = '0;
      endcase
    end
  end

  assign mask_hit = bit_en && (clr != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mk_q  <= '0;
      du_q  <= '0;
      vi_q  <= '0;
      ez_q  <= '0;
      err_q <= 1'b0;
    end else if (bit_en) begin
      err_q <= vi_q[WIN-1] | ez_q[WIN-1];
      mk_q  <= win_mk[WIN-2:0];
      du_q  <= win_du[WIN-2:0];
      vi_q  <= win_vi & ~clr;
      ez_q  <= win_ez;
    end
  end
endmodule

// File: rtl/bpv_exz_detector.sv
module bpv_exz_detector #(
  parameter int unsigned AMI_RUN  = 16,
  parameter int unsigned B8ZS_RUN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rail_p,
  input  logic       rail_n,
  input  logic       dec_en,
  input  logic [1:0] code_sel,
  input  logic       e1_mode,
  input  logic       exz_en,
  output logic       bpv_pulse
);
  logic is_mark, is_dual, raw_vio, exz_hit, mask_hit;

  bpv_mark_tracker u_mark (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rail_p(rail_p), .rail_n(rail_n),
    .is_mark(is_mark), .is_dual(is_dual), .raw_vio(raw_vio)
  );

  bpv_zero_run #(.AMI_RUN(AMI_RUN), .B8ZS_RUN(B8ZS_RUN)) u_zero (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .is_mark(is_mark),
    .code_sel(code_sel), .e1_mode(e1_mode), .exz_en(exz_en), .exz_hit(exz_hit)
  );

  bpv_subst_window u_win (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .is_mark(is_mark), .is_dual(is_dual),
    .raw_vio(raw_vio), .exz_hit(exz_hit), .dec_en(dec_en), .code_sel(code_sel),
    .mask_hit(mask_hit), .err_q(bpv_pulse)
  );
endmodule

// File: rtl/bpv_chk.sv
module bpv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       rail_p,
  input logic       rail_n,
  input logic       dec_en,
  input logic [1:0] code_sel,
  input logic       e1_mode,
  input logic       exz_en,
  input logic       raw_vio,
  input logic       exz_hit,
  input logic       mask_hit,
  input logic       bpv_pulse
);
  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(bpv_pulse)); // R1
  AST_DUAL_IS_VIO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && rail_p && rail_n) |-> raw_vio); // R3
  AST_NO_MASK_DEC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |-> !mask_hit); // R6
  AST_NO_MASK_AMI: assert property (@(posedge clk) disable iff (!rst_n)
    (code_sel == 2'd0) |-> !mask_hit); // R4
  AST_RUN_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    exz_hit |-> (bit_en && !rail_p && !rail_n)); // R7
  AST_RUN_OFF_E1: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_mode || !exz_en || code_sel == 2'd2) |-> !exz_hit); // R9
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> !bpv_pulse); // R10
endmodule

bind bpv_exz_detector bpv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rail_p(rail_p), .rail_n(rail_n),
  .dec_en(dec_en), .code_sel(code_sel), .e1_mode(e1_mode), .exz_en(exz_en),
  .raw_vio(raw_vio), .exz_hit(exz_hit), .mask_hit(mask_hit), .bpv_pulse(bpv_pulse)
);

// File: tb/bpv_exz_detector_tb.sv
module bpv_exz_detector_tb_top;
  localparam int CLK_P = 10;
  localparam int MAXB  = 700;

  logic       clk = 1'b0;
  logic       rst_n, bit_en, rail_p, rail_n, dec_en, e1_mode, exz_en;
  logic [1:0] code_sel;
  logic       bpv_pulse;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  bit sp[MAXB], sn[MAXB], ev[MAXB];
  bit mk[MAXB], vi[MAXB], du[MAXB], ez[MAXB];
  int nb;
  bit gen_last;

  bpv_exz_detector dut_i (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit act, input bit exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: bpv_pulse=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // ---- stimulus building
  task automatic put(input bit p, input bit n);
    if (nb < MAXB) begin
      sp[nb] = p; sn[nb] = n; nb++;
      if (p ^ n) gen_last = n;
    end
  endtask
  task automatic put_zero(); put(0, 0); endtask
  task automatic put_alt();  put(gen_last, !gen_last); endtask
  task automatic put_same(); put(!gen_last, gen_last); endtask
  task automatic put_b8zs();
    put_zero(); put_zero(); put_zero(); put_same(); put_alt(); put_zero(); put_same(); put_alt();
  endtask
  task automatic put_hdb3();
    if ($urandom % 2) begin put_zero(); put_zero(); put_zero(); put_same(); end
    else begin put_alt(); put_zero(); put_zero(); put_same(); end
  endtask

  // kind: 0 none, 1 b8zs words, 2 hdb3 words
  task automatic gen(input int len, input int pv, input int pd, input int psub,
                     input int kind, input int prun);
    int r;
    nb = 0; gen_last = 1;
    while (nb < len) begin
      r = int'($urandom % 100);
      if (r < psub) begin if (kind == 1) put_b8zs(); else if (kind == 2) put_hdb3(); end
      else if (r < psub + prun) begin
        int rl = 6 + int'($urandom % 35);
        for (int k = 0; k < rl; k++) put_zero();
      end
      else if (r < psub + prun + pv) put_same();
      else if (r < psub + prun + pv + pd) put(1, 1);
      else if (r < 70) put_zero();
      else put_alt();
    end
  endtask

  // ---- reference model from the requirements
  function automatic int run_limit(input logic [1:0] c, input bit e1, input bit en);
    if (!en || e1 || c == 2'd2) return 0;
    return (c == 2'd1) ? 8 : 16;
  endfunction

  function automatic bit gm(input int i); return (i < 0) ? 1'b0 : mk[i]; endfunction
  function automatic bit gv(input int i); return (i < 0) ? 1'b0 : vi[i]; endfunction
  function automatic bit gd(input int i); return (i < 0) ? 1'b0 : du[i]; endfunction
  function automatic bit isv(input int i); return gm(i) && gv(i) && !gd(i); endfunction
  function automatic bit isb(input int i); return gm(i) && !gv(i); endfunction

  task automatic model(input logic [1:0] c, input bit dec, input bit e1, input bit en);
    bit seen = 0, lp = 0;
    int run = 0, lim;
    lim = run_limit(c, e1, en);
    for (int i = 0; i < nb; i++) begin
      mk[i] = sp[i] | sn[i];
      du[i] = sp[i] & sn[i];
      vi[i] = du[i] || ((sp[i] ^ sn[i]) && seen && (sn[i] == lp));
      if (sp[i] ^ sn[i]) begin seen = 1; lp = sn[i]; end
      if (mk[i]) run = 0; else run++;
      ez[i] = (lim != 0) && !mk[i] && (run == lim);
      if (dec && c == 2'd1 && !gm(i-7) && !gm(i-6) && !gm(i-5) && isv(i-4) && isb(i-3)
          && !gm(i-2) && isv(i-1) && isb(i)) begin
        vi[i-4] = 0; vi[i-1] = 0;
      end
      if (dec && c == 2'd2 && (!gm(i-3) || isb(i-3)) && !gm(i-2) && !gm(i-1) && isv(i))
        vi[i] = 0;
    end
    for (int i = 0; i < nb; i++) ev[i] = vi[i] | ez[i];
  endtask

  task automatic do_reset();
    rst_n = 0; bit_en = 0; rail_p = 0; rail_n = 0;
    repeat (3) @(negedge clk);
    check(bpv_pulse, 1'b0, "R10 reset");
    rst_n = 1;
  endtask

  task automatic run_seg(input logic [1:0] c, input bit dec, input bit e1, input bit en,
                         input string tag);
    bit exp;
    code_sel = c; dec_en = dec; e1_mode = e1; exz_en = en;
    model(c, dec, e1, en);
    do_reset();
    for (int m = 0; m < nb + 8; m++) begin
      bit_en = 1;
      rail_p = (m < nb) ? sp[m] : 1'b1;
      rail_n = 1'b0;
      if (m < nb) rail_n = sn[m];
      else rail_n = (m % 2) == 0;
      @(negedge clk);
      exp = (m >= 8) ? ev[m-8] : 1'b0;
      check(bpv_pulse, exp, (m < 8) ? "R10 empty line" : tag);
      bit_en = 0;
      repeat (int'($urandom % 3)) begin
        @(negedge clk);
        check(bpv_pulse, exp, "R1 hold");
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0b17));
    rst_n = 0; bit_en = 0; rail_p = 0; rail_n = 0;
    dec_en = 0; code_sel = 0; e1_mode = 0; exz_en = 0;
    @(negedge clk);
    gen(400, 0, 0, 0, 0, 0);  run_seg(2'd0, 0, 0, 0, "R1 clean AMI");
    gen(400, 12, 0, 0, 0, 0); run_seg(2'd0, 1, 0, 0, "R2 polarity");
    gen(400, 6, 10, 0, 0, 0); run_seg(2'd1, 1, 0, 0, "R3 dual rail");
    gen(500, 5, 3, 12, 1, 0); run_seg(2'd1, 1, 0, 0, "R4 B8ZS mask");
    gen(500, 5, 3, 15, 2, 0); run_seg(2'd2, 1, 1, 1, "R5 HDB3 mask");
    gen(400, 3, 0, 15, 1, 0); run_seg(2'd1, 0, 0, 0, "R6 dec off");
    gen(600, 3, 2, 0, 0, 12); run_seg(2'd0, 0, 0, 1, "R7 AMI 16 zeros");
    gen(600, 3, 0, 0, 0, 12); run_seg(2'd3, 0, 0, 1, "R7 code 3 as AMI");
    gen(600, 3, 0, 8, 1, 12); run_seg(2'd1, 1, 0, 1, "R8 B8ZS 8 zeros");
    gen(500, 3, 0, 0, 0, 12); run_seg(2'd1, 0, 1, 1, "R9 E1 off");
    gen(500, 3, 0, 0, 0, 12); run_seg(2'd0, 0, 0, 0, "R9 enable off");
    gen(500, 3, 0, 0, 0, 12); run_seg(2'd2, 0, 0, 1, "R9 HDB3 code");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule